// File: doc/BRIEF.md
# Instruction TLB Victim Selector

This block holds the six-bit replacement state of a four-way, fully associative instruction translation buffer and names the slot to overwrite when a refill arrives. Each bit records the relative age of one pair of slots. A lookup that hits reports the slot it used. The block then sets some state bits and clears others, using a fixed pattern for each slot. A refill marks the chosen slot as used by the same rule.

The victim is decoded combinationally from the current state through four ordered pattern tests. When no test matches, the block raises a flag and falls back to slot 0. The state is the upper six bits of the MMU control register. Software can load it through a write port that takes priority over every other update. The tag compare and the copy of the new translation into the chosen slot belong to the surrounding logic.

In this document S5..S0 name the state bits, with S5 the most significant bit of `state_o`.

Top module: `itlb_victim_sel`

## Requirements
- R1: While reset is held, and after it is released with no other input active, `state_o` equals the parameter `RESET_STATE` (default 6'b000000). With the default, `victim_o` is 3 and `state_bad_o` is 0.
- R2: A use of slot 0 (use_vld_i=1, use_idx_i=0) clears S5, S4 and S3 on the next clock edge and leaves S2..S0 unchanged.
- R3: A use of slot 1 sets S5 and clears S2 and S1 on the next clock edge. Every other bit keeps its value.
- R4: A use of slot 2 sets S4 and S2 and clears S0 on the next clock edge. Every other bit keeps its value.
- R5: A use of slot 3 sets S3, S1 and S0 on the next clock edge. Every other bit keeps its value.
- R6: When S5, S4 and S3 are all 1, `victim_o` is 0. This test has the highest priority.
- R7: Otherwise, when S5=0, S2=0 and S1=1, `victim_o` is 1.
- R8: Otherwise, when S4=0, S2=0 and S0=1, `victim_o` is 2.
- R9: Otherwise, when S3, S1 and S0 are all 0, `victim_o` is 3.
- R10: When none of the four tests matches, `state_bad_o` is 1 and `victim_o` is 0. Otherwise `state_bad_o` is 0.
- R11: On a refill (refill_i=1), the state on the next edge is the result of applying the use rule of the slot that `victim_o` named in that cycle.
- R12: A software write (wr_en_i=1) loads `wr_state_i` into the state on the next edge. Any refill or use in the same cycle is ignored.
- R13: A refill in the same cycle as a use takes precedence, and the use is ignored. With no write, refill or use, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_vld_i | input | 1 | A lookup hit a slot this cycle |
| use_idx_i | input | 2 | Slot that was hit |
| refill_i | input | 1 | Refill request; the victim is marked as used |
| wr_en_i | input | 1 | Software load of the state |
| wr_state_i | input | 6 | Value loaded by a software write |
| victim_o | output | 2 | Slot to overwrite on a refill |
| state_bad_o | output | 1 | No victim pattern matched the state |
| state_o | output | 6 | Current state (S5..S0) |

## Verification
A wrong set or clear mask shows up on `state_o` one clock after the use that applied it. Through the decoder, it can also change `victim_o` in that same later cycle. A fault in the pattern decoder needs no clock at all: the victim and the bad-state flag are wrong as soon as the state holding the matching pattern is loaded. The bench therefore loads chosen states through the write port and reads the decode immediately. It then checks each mask and each priority conflict one edge after the stimulus.

// File: rtl/itlb_victim_pkg.sv
package itlb_victim_pkg;

   localparam int unsigned SLOTS    = 4;
   localparam int unsigned SLOT_W   = 2;
   localparam int unsigned AGE_W    = 6;

   typedef logic [AGE_W-1:0]  age_t;
   typedef logic [SLOT_W-1:0] slot_t;

   // bits that survive a use of slot s
   function automatic age_t keep_mask(input slot_t s);
      case (s)
         2'd0:    keep_mask = 6'b000_111;
         2'd1:    keep_mask = 6'b011_001;
         2'd2:    keep_mask = 6'b101_010;
         default: keep_mask = 6'b110_100;
      endcase
   endfunction

   // bits forced to one by a use of slot s
   function automatic age_t set_mask(input slot_t s);
      case (s)
         2'd0:    set_mask = 6'b000_000;
         2'd1:    set_mask = 6'b100_000;
         2'd2:    set_mask = 6'b010_100;
         default: set_mask = 6'b001_011;
      endcase
   endfunction

   // bits inspected by the victim test of slot s
   function automatic age_t care_mask(input slot_t s);
      case (s)
         2'd0:    care_mask = 6'b111_000;
         2'd1:    care_mask = 6'b100_110;
         2'd2:    care_mask = 6'b010_101;
         default: care_mask = 6'b001_011;
      endcase
   endfunction

   // required value of the inspected bits
   function automatic age_t want_val(input slot_t s);
      case (s)
         2'd0:    want_val = 6'b111_000;
         2'd1:    want_val = 6'b000_010;
         2'd2:    want_val = 6'b000_001;
         default: want_val = 6'b000_000;
      endcase
   endfunction

endpackage

// File: rtl/itlb_age_update.sv
module itlb_age_update
   import itlb_victim_pkg::*;
#(
   parameter int unsigned AW = AGE_W,
   parameter int unsigned SW = SLOT_W
) (
   input  logic [AW-1:0] cur_i,
   input  logic          en_i,
   input  logic [SW-1:0] slot_i,
   output logic [AW-1:0] nxt_o
);

   age_t keep_w;
   age_t set_w;

   assign keep_w = keep_mask(slot_t'(slot_i));
   assign set_w  = set_mask(slot_t'(slot_i));

   for (genvar b = 0; b < int'(AW); b++) begin : g_bit
      assign nxt_o[b] = en_i ? ((cur_i[b] & keep_w[b]) | set_w[b]) : cur_i[b];
   end

endmodule

// File: rtl/itlb_victim_decode.sv
module itlb_victim_decode
   import itlb_victim_pkg::*;
#(
   parameter int unsigned AW = AGE_W,
   parameter int unsigned SW = SLOT_W,
   parameter int unsigned N  = SLOTS
) (
   input  logic [AW-1:0] age_i,
   output logic [SW-1:0] victim_o,
   output logic          bad_o
);

   logic [N-1:0] hit_w;

   for (genvar e = 0; e < int'(N); e++) begin : g_test
      localparam slot_t SE = slot_t'(e);
      assign hit_w[e] = ((age_i & care_mask(SE)) == want_val(SE));
   end

   // lowest-numbered matching test wins
   always_comb begin
      victim_o = '0;
      for (int e = int'(N) - 1; e >= 0; e--) begin
         if (hit_w[e]) victim_o = SW'(e);
      end
   end

   assign bad_o = ~|hit_w;

endmodule

// File: rtl/itlb_victim_sel.sv
module itlb_victim_sel
   import itlb_victim_pkg::*;
#(
   parameter int unsigned   NUM_SLOTS   = 4,
   parameter int unsigned   STATE_W     = 6,
   parameter logic [5:0]    RESET_STATE = 6'b000000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         use_vld_i,
   input  logic [$clog2(NUM_SLOTS)-1:0] use_idx_i,
   input  logic                         refill_i,
   input  logic                         wr_en_i,
   input  logic [STATE_W-1:0]           wr_state_i,
   output logic [$clog2(NUM_SLOTS)-1:0] victim_o,
   output logic                         state_bad_o,
   output logic [STATE_W-1:0]           state_o
);

   localparam int unsigned IW = $clog2(NUM_SLOTS);

   if (NUM_SLOTS != SLOTS) begin : g_bad_slots
      $error("itlb_victim_sel: encoding is fixed at four slots");
   end
   if (STATE_W != AGE_W) begin : g_bad_width
      $error("itlb_victim_sel: state must be six bits");
   end

   logic [STATE_W-1:0] age_q;
   logic [STATE_W-1:0] age_upd;
   logic [STATE_W-1:0] age_d;
   logic [IW-1:0]      upd_slot;
   logic               upd_en;

   itlb_victim_decode #(.AW(STATE_W), .SW(IW), .N(NUM_SLOTS)) u_dec (
      .age_i    (age_q),
      .victim_o (victim_o),
      .bad_o    (state_bad_o)
   );

   // refill marks its victim; otherwise the hit slot is marked
   assign upd_slot = refill_i ? victim_o : use_idx_i;
   assign upd_en   = refill_i | use_vld_i;

   itlb_age_update #(.AW(STATE_W), .SW(IW)) u_upd (
      .cur_i  (age_q),
      .en_i   (upd_en),
      .slot_i (upd_slot),
      .nxt_o  (age_upd)
   );

   assign age_d = wr_en_i ? wr_state_i : age_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= RESET_STATE;
      else        age_q <= age_d;
   end

   assign state_o = age_q;

endmodule

// File: rtl/itlb_victim_sel_chk.sv
module itlb_victim_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       use_vld_i,
   input logic [1:0] use_idx_i,
   input logic       refill_i,
   input logic       wr_en_i,
   input logic [5:0] wr_state_i,
   input logic [1:0] victim_o,
   input logic       state_bad_o,
   input logic [5:0] state_o
);

   logic only_use;
   assign only_use = use_vld_i && !refill_i && !wr_en_i;

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> state_o == $past(wr_state_i)); // R12

   AST_USE_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      only_use && use_idx_i == 2'd0 |=> state_o[5:3] == 3'b000 && state_o[2:0] == $past(state_o[2:0])); // R2

   AST_USE_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
      only_use && use_idx_i == 2'd1 |=> state_o[5] && !state_o[2] && !state_o[1]); // R3

   AST_USE_SLOT2: assert property (@(posedge clk) disable iff (!rst_n)
      only_use && use_idx_i == 2'd2 |=> state_o[4] && state_o[2] && !state_o[0]); // R4

   AST_USE_SLOT3: assert property (@(posedge clk) disable iff (!rst_n)
      only_use && use_idx_i == 2'd3 |=> state_o[3] && state_o[1] && state_o[0]); // R5

   AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      state_o[5:3] == 3'b111 |-> victim_o == 2'd0 && !state_bad_o); // R6

   AST_BAD_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      state_bad_o |-> victim_o == 2'd0); // R10

   AST_REFILL_SLOT3: assert property (@(posedge clk) disable iff (!rst_n)
      refill_i && !wr_en_i && victim_o == 2'd3 |=> state_o[3] && state_o[1] && state_o[0]); // R11

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i && !refill_i && !use_vld_i |=> $stable(state_o)); // R13

endmodule

bind itlb_victim_sel itlb_victim_sel_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .use_vld_i   (use_vld_i),
   .use_idx_i   (use_idx_i),
   .refill_i    (refill_i),
   .wr_en_i     (wr_en_i),
   .wr_state_i  (wr_state_i),
   .victim_o    (victim_o),
   .state_bad_o (state_bad_o),
   .state_o     (state_o)
);

// File: tb/itlb_victim_sel_tb.sv
module itlb_victim_sel_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       use_vld = 1'b0;
   logic [1:0] use_idx = 2'd0;
   logic       refill = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_state = 6'd0;
   logic [1:0] victim;
   logic       bad;
   logic [5:0] state;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   itlb_victim_sel u_dut (
      .clk (clk), .rst_n (rst_n),
      .use_vld_i (use_vld), .use_idx_i (use_idx),
      .refill_i (refill), .wr_en_i (wr_en), .wr_state_i (wr_state),
      .victim_o (victim), .state_bad_o (bad), .state_o (state)
   );

   // expected behaviour written from the requirement text
   function automatic logic [5:0] exp_use(input logic [5:0] s, input logic [1:0] k);
      logic [5:0] r = s;
      case (k)
         2'd0: begin r[5] = 0; r[4] = 0; r[3] = 0; end
         2'd1: begin r[5] = 1; r[2] = 0; r[1] = 0; end
         2'd2: begin r[4] = 1; r[2] = 1; r[0] = 0; end
         default: begin r[3] = 1; r[1] = 1; r[0] = 1; end
      endcase
      return r;
   endfunction

   function automatic logic [2:0] exp_vic(input logic [5:0] s); // {bad, idx}
      if (s[5] && s[4] && s[3])          return 3'b0_00;
      if (!s[5] && !s[2] && s[1])        return 3'b0_01;
      if (!s[4] && !s[2] && s[0])        return 3'b0_10;
      if (!s[3] && !s[1] && !s[0])       return 3'b0_11;
      return 3'b1_00;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      use_vld = 0; refill = 0; wr_en = 0;
   endtask

   task automatic load(input logic [5:0] v);
      wr_en = 1; wr_state = v;
      step();
   endtask

   task automatic t_reset();
      check("R1 state", {2'b0, state}, 8'h00);
      check("R1 victim", {5'b0, bad, victim}, 8'h03);
      rst_n = 1;
      step();
      check("R1 after release", {2'b0, state}, 8'h00);
   endtask

   task automatic t_uses();
      logic [5:0] start [4] = '{6'b111111, 6'b000000, 6'b101010, 6'b010101};
      for (int k = 0; k < 4; k++) begin
         for (int p = 0; p < 4; p++) begin
            load(start[p]);
            use_vld = 1; use_idx = 2'(k);
            step();
            case (k)
               0: check("R2 use slot0", {2'b0, state}, {2'b0, exp_use(start[p], 2'd0)});
               1: check("R3 use slot1", {2'b0, state}, {2'b0, exp_use(start[p], 2'd1)});
               2: check("R4 use slot2", {2'b0, state}, {2'b0, exp_use(start[p], 2'd2)});
               default: check("R5 use slot3", {2'b0, state}, {2'b0, exp_use(start[p], 2'd3)});
            endcase
         end
      end
   endtask

   task automatic t_decode();
      load(6'b111000); check("R6 victim0", {5'b0, bad, victim}, 8'h00);
      load(6'b111111); check("R6 priority", {5'b0, bad, victim}, 8'h00);
      load(6'b000010); check("R7 victim1", {5'b0, bad, victim}, 8'h01);
      load(6'b000011); check("R7 over R8", {5'b0, bad, victim}, 8'h01);
      load(6'b000001); check("R8 victim2", {5'b0, bad, victim}, 8'h02);
      load(6'b000000); check("R9 victim3", {5'b0, bad, victim}, 8'h03);
      load(6'b110100); check("R9 victim3 b", {5'b0, bad, victim}, 8'h03);
      load(6'b001100); check("R10 bad state", {5'b0, bad, victim}, 8'h04);
      for (int v = 0; v < 64; v++) begin
         load(6'(v));
         check("R10 sweep", {5'b0, bad, victim}, {5'b0, exp_vic(6'(v))});
      end
   endtask

   task automatic t_refill();
      logic [5:0] s;
      logic [2:0] ev;
      s = 6'b000000;
      load(s);
      for (int n = 0; n < 8; n++) begin
         ev = exp_vic(s);
         refill = 1;
         step();
         s = exp_use(s, ev[1:0]);
         check("R11 refill marks victim", {2'b0, state}, {2'b0, s});
      end
      load(6'b000010);
      refill = 1; use_vld = 1; use_idx = 2'd3;
      step();
      check("R13 refill beats use", {2'b0, state}, {2'b0, exp_use(6'b000010, 2'd1)});
      step(); step();
      check("R13 idle hold", {2'b0, state}, {2'b0, exp_use(6'b000010, 2'd1)});
   endtask

   task automatic t_write();
      load(6'b000000);
      wr_en = 1; wr_state = 6'b011011; refill = 1; use_vld = 1; use_idx = 2'd1;
      step();
      check("R12 write wins", {2'b0, state}, 8'h1B);
      load(6'b100101);
      check("R12 plain write", {2'b0, state}, 8'h25);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_uses();
      t_decode();
      t_refill();
      t_write();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule